// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block keeps the eight-bit status byte of a serial memory and decides, every cycle, whether a pending array write and a pending status write are allowed. A command decoder in front of it delivers one-cycle pulses: set the write-enable latch, clear it, and a status write carrying its completed data byte. The block also sees the level of the external write-protect pin and the target address of the array write about to be committed. It answers with the status byte for read-back and two permit flags.

The upper six bits (protect-enable, three spare bits and the two-bit protected-range field) stand in for nonvolatile cells. They come out of reset with a parameter value, so a system model can preload them. The write-enable latch is volatile and comes out of reset cleared. It is not dropped when a write finishes, so a host can program repeatedly after a single enable command.

Top module: `wprot_status_unit`

## Requirements
- R1: After reset the status byte reads {INIT_NV, 2'b00}, the write-enable latch (bit 1) is 0, and both permit outputs are 0.
- R2: A set pulse makes status bit 1 read 1 from the next cycle. A clear pulse makes it read 0 from the next cycle. When both pulses arrive in the same cycle, clear wins.
- R3: Status bit 0 always reads 0.
- R4: An accepted status write loads data bits 7 to 2 into status bits 7 to 2 on the clock edge that ends its cycle. Data bits 1 and 0 are ignored.
- R5: Bit 1 (the write-enable latch) keeps its value across a status write and changes only on a set or clear pulse.
- R6: The status-write permit is high exactly when bit 1 is 1 and either bit 7 (protect-enable) is 0 or the write-protect pin is high. A rejected status write leaves bits 7 to 2 unchanged.
- R7: While bit 1 is 0, both permits are 0.
- R8: Status bits 3:2 select the protected array range: 00 nothing, 01 the top quarter of the address space, 10 the top half, 11 all of it. An address inside the range never gets the array-write permit, whatever bit 1 holds. Any other address gets the permit when bit 1 is 1.
- R9: The write-protect pin level is taken in the same cycle as the status-write pulse. Its level in any other cycle has no effect on that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_wel_i | input | 1 | Pulse: set the write-enable latch |
| clr_wel_i | input | 1 | Pulse: clear the write-enable latch |
| sr_wr_i | input | 1 | Pulse: status-write data byte complete |
| sr_wr_data_i | input | 8 | Status-write data byte |
| wp_i | input | 1 | Write-protect pin level (1 = high) |
| arr_addr_i | input | ADDR_W | Target address of the pending array write |
| status_o | output | 8 | Status byte for read-back |
| arr_wr_ok_o | output | 1 | Array write permitted at arr_addr_i |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
The bench builds the unit with ADDR_W = 18 and INIT_NV = 6'b010101. Because of that nonzero preload, the reset value shows the spare bits, and a quarter-range protection is active from the first cycle. The 18-bit address lets exact range edges such as 0x2FFFF/0x30000 and 0x1FFFF/0x20000 be probed for each protection setting. A table of pulse, data, pin and address vectors is walked against a behavioural model in the bench. Directed steps then exercise pin timing on protected status writes and a mid-run reset.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam int unsigned SR_W = 8;
  // Bits that a status write may load; bits 1 and 0 are never taken from data.
  localparam logic [SR_W-1:0] SR_NV_MASK = 8'hFC;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_e;

  // Keep only the loadable bits of an incoming status byte.
  function automatic logic [SR_W-1:0] sr_merge(input logic [SR_W-1:0] din);
    return din & SR_NV_MASK;
  endfunction

  // Lowest protected address for a range setting, in an aw-bit space.
  function automatic logic [63:0] prot_floor(input bp_e bp, input int unsigned aw);
    case (bp)
      BP_QUARTER: return 64'(3) << (aw - 2);
      BP_HALF:    return 64'(1) << (aw - 1);
      default:    return 64'(0);
    endcase
  endfunction

  // Status-write permission from latch, protect-enable and pin level.
  function automatic logic sr_write_allowed(input logic wel, input logic wpen,
                                            input logic wp);
    return wel & (~wpen | wp);
  endfunction

endpackage

// File: rtl/wprot_wel_latch.sv
module wprot_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end

endmodule

// File: rtl/wprot_nv_reg.sv
module wprot_nv_reg
  import wprot_pkg::*;
#(
  parameter logic [5:0] INIT_NV = 6'b000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_i,
  input  logic [SR_W-1:0] din_i,
  output logic [SR_W-1:0] nv_o
);

  localparam logic [SR_W-1:0] RESET_VAL = {INIT_NV, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        nv_o <= RESET_VAL;
    else if (commit_i) nv_o <= sr_merge(din_i);
  end

endmodule

// File: rtl/wprot_range_dec.sv
module wprot_range_dec
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  logic [63:0] addr_x;
  logic [63:0] floor_x;
  bp_e         bp;

  assign bp      = bp_e'(bp_i);
  assign addr_x  = 64'(addr_i);
  assign floor_x = prot_floor(bp, ADDR_W);
  assign hit_o   = (bp != BP_NONE) && (addr_x >= floor_x);

endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter logic [5:0]  INIT_NV = 6'b000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_wr_data_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  output logic [7:0]        status_o,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o
);

  localparam int unsigned WPEN_BIT = SR_W - 1;

  logic            wel_q;
  logic [SR_W-1:0] nv_q;
  logic            sr_commit;
  logic            blk_hit;

  wprot_wel_latch u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_wel_i),
    .clr_i (clr_wel_i),
    .wel_o (wel_q)
  );

  assign sr_wr_ok_o = sr_write_allowed(wel_q, nv_q[WPEN_BIT], wp_i);
  assign sr_commit  = sr_wr_i & sr_wr_ok_o;

  wprot_nv_reg #(.INIT_NV(INIT_NV)) u_nv (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (sr_commit),
    .din_i    (sr_wr_data_i),
    .nv_o     (nv_q)
  );

  wprot_range_dec #(.ADDR_W(ADDR_W)) u_range (
    .bp_i   (nv_q[3:2]),
    .addr_i (arr_addr_i),
    .hit_o  (blk_hit)
  );

  assign arr_wr_ok_o = wel_q & ~blk_hit;
  assign status_o    = nv_q | {6'b000000, wel_q, 1'b0};

endmodule

// File: rtl/wprot_status_unit_chk.sv
module wprot_status_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_wel_i,
  input logic       clr_wel_i,
  input logic       sr_wr_i,
  input logic [7:0] sr_wr_data_i,
  input logic       wp_i,
  input logic [7:0] status_o,
  input logic       arr_wr_ok_o,
  input logic       sr_wr_ok_o,
  input logic       sr_commit,
  input logic       blk_hit
);

  assert_bit0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] == 1'b0);

  assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wel_i && !clr_wel_i) |=> status_o[1]);

  assert_wel_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wel_i |=> !status_o[1]);

  assert_wel_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wel_i && !clr_wel_i) |=> $stable(status_o[1]));

  assert_sr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit |=> status_o[7:2] == $past(sr_wr_data_i[7:2]));

  assert_sr_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && !sr_wr_ok_o) |=> $stable(status_o[7:2]));

  assert_sr_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] && status_o[7] && !wp_i) |-> !sr_wr_ok_o);

  assert_sr_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] && (!status_o[7] || wp_i)) |-> sr_wr_ok_o);

  assert_no_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[1] |-> (!arr_wr_ok_o && !sr_wr_ok_o));

  assert_blk_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hit |-> !arr_wr_ok_o);

  assert_all_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:2] == 2'b11) |-> blk_hit);

endmodule

bind wprot_status_unit wprot_status_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .set_wel_i    (set_wel_i),
  .clr_wel_i    (clr_wel_i),
  .sr_wr_i      (sr_wr_i),
  .sr_wr_data_i (sr_wr_data_i),
  .wp_i         (wp_i),
  .status_o     (status_o),
  .arr_wr_ok_o  (arr_wr_ok_o),
  .sr_wr_ok_o   (sr_wr_ok_o),
  .sr_commit    (sr_commit),
  .blk_hit      (blk_hit)
);

// File: tb/wprot_status_unit_bench.sv
module wprot_status_unit_bench;

  localparam int unsigned AW      = 18;
  localparam logic [5:0]  INIT_NV = 6'b010101;
  localparam int          NVEC    = 16;

  // {set, clr, srw, data[7:0], wp, addr[17:0]}
  localparam logic [29:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 18'h00000},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 18'h00000},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 18'h30000},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 18'h2FFFF},
    {1'b0, 1'b0, 1'b1, 8'h8B, 1'b0, 18'h00000},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 18'h20000},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 18'h1FFFF},
    {1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 18'h00000},
    {1'b0, 1'b0, 1'b1, 8'h0C, 1'b1, 18'h00000},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 18'h00000},
    {1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 18'h00000},
    {1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 18'h00000},
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 18'h00000},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 18'h00000},
    {1'b0, 1'b0, 1'b1, 8'h70, 1'b1, 18'h00000},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 18'h3FFFF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_wel_i = 1'b0, clr_wel_i = 1'b0, sr_wr_i = 1'b0, wp_i = 1'b0;
  logic [7:0]    sr_wr_data_i = 8'h00;
  logic [AW-1:0] arr_addr_i = '0;
  logic [7:0]    status_o;
  logic          arr_wr_ok_o, sr_wr_ok_o;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model state
  logic       m_wel;
  logic [5:0] m_nv;

  always #10 clk = ~clk;

  wprot_status_unit #(.ADDR_W(AW), .INIT_NV(INIT_NV)) u_wprot_status_unit (
    .clk(clk), .rst_n(rst_n), .set_wel_i(set_wel_i), .clr_wel_i(clr_wel_i),
    .sr_wr_i(sr_wr_i), .sr_wr_data_i(sr_wr_data_i), .wp_i(wp_i),
    .arr_addr_i(arr_addr_i), .status_o(status_o),
    .arr_wr_ok_o(arr_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o)
  );

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic model_in_range(input logic [5:0] nv, input logic [AW-1:0] a);
    case (nv[1:0])
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1] & a[AW-2];
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] model_status();
    return {m_nv, m_wel, 1'b0};
  endfunction

  task automatic apply(input logic [29:0] v, input int idx);
    logic exp_sr, exp_arr;
    @(negedge clk);
    set_wel_i    = v[29];
    clr_wel_i    = v[28];
    sr_wr_i      = v[27];
    sr_wr_data_i = v[26:19];
    wp_i         = v[18];
    arr_addr_i   = v[17:0];
    #2;
    exp_sr  = m_wel & (~m_nv[5] | wp_i);
    exp_arr = m_wel & ~model_in_range(m_nv, arr_addr_i);
    check($sformatf("R6/R7 status-write permit, step %0d", idx), {7'b0, sr_wr_ok_o}, {7'b0, exp_sr});
    check($sformatf("R8/R7 array-write permit, step %0d", idx), {7'b0, arr_wr_ok_o}, {7'b0, exp_arr});
    @(negedge clk);
    if (v[28])      m_wel = 1'b0;
    else if (v[29]) m_wel = 1'b1;
    if (v[27] && exp_sr) m_nv = v[26:21];
    set_wel_i = 1'b0; clr_wel_i = 1'b0; sr_wr_i = 1'b0;
    #1;
    check($sformatf("R2/R3/R4/R5 status byte, step %0d", idx), status_o, model_status());
  endtask

  initial begin
    m_wel = 1'b0;
    m_nv  = INIT_NV;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 reset status", status_o, 8'h54);
    check("R1 reset array permit", {7'b0, arr_wr_ok_o}, 8'h00);
    check("R1 reset status permit", {7'b0, sr_wr_ok_o}, 8'h00);

    for (int i = 0; i < NVEC; i++) apply(VECS[i], i);

    // R9: pin level only matters in the write cycle
    apply({1'b0, 1'b0, 1'b1, 8'h80, 1'b0, 18'h00000}, 100); // protect-enable on
    apply({1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 18'h00000}, 101); // pin high, no write
    apply({1'b0, 1'b0, 1'b1, 8'h84, 1'b0, 18'h00000}, 102); // pin low at write: rejected
    check("R9 write with pin low rejected", status_o, 8'h82);
    apply({1'b0, 1'b0, 1'b1, 8'h07, 1'b1, 18'h00000}, 103); // pin high at write: accepted
    check("R9 write with pin high accepted, R4 low bits ignored", status_o, 8'h06);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_wel = 1'b0;
    m_nv  = INIT_NV;
    #1;
    check("R1 status after second reset", status_o, 8'h54);
    check("R1 array permit after second reset", {7'b0, arr_wr_ok_o}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule